// File: doc/BRIEF.md
# Magic Packet Frame Detector

This block watches a byte-wide receive stream and decides, frame by frame, whether the frame is a wake-up ("magic") packet for this station. Each beat carries one byte with start-of-frame and end-of-frame markers. Once the header is past, the block scans every payload byte for an unbroken run of sixteen copies of the station's 48-bit physical address. The run may begin at any payload offset.

A frame qualifies only when an external address filter also reports an acceptable destination match. A unicast match always qualifies. A multicast or broadcast match qualifies only when the accept-group configuration bit is set. Whatever that bit says, the repeated pattern must always be the station's own physical address.

On the beat that carries end-of-frame, the block checks the scan result and the match inputs. If the frame passes, it raises a one-cycle detect pulse on the following clock. The station address and the enable bit are static inputs supplied by the surrounding logic.

Top module: `mp_frame_detector`

## Requirements
- R1: After a synchronous reset, `detect` is low.
- R2: A frame whose payload holds 16 back-to-back copies of `station_addr` is detected when it also has a qualifying address match. Each copy is sent lowest byte first, starting with bits 7:0. The run may start at any payload offset.
- R3: A run of only 15 consecutive copies, or a run that one foreign byte breaks, produces no detection.
- R4: Beats 0 to 13 of each frame, counted from the start-of-frame beat as beat 0, form the header and are never scanned. Payload scanning starts at beat 14.
- R5: When a payload byte fails to match partway through a run, the scan restarts. If that byte equals bits 7:0 of the address, it counts as the first byte of a new run. Otherwise the new run starts with the next byte.
- R6: `hit_unicast` qualifies the frame whatever the value of `accept_grp_bcast`.
- R7: `hit_multicast` and `hit_broadcast` qualify the frame only when `accept_grp_bcast` is 1.
- R8: With no qualifying match input high on the end-of-frame beat, a frame holding a full run is not detected.
- R9: While `enable` is 0 nothing is detected, and any scan progress or completed run is discarded.
- R10: `detect` is high for exactly one cycle, the cycle after the end-of-frame beat. The match inputs are sampled on that end-of-frame beat.
- R11: A start-of-frame beat discards the scan state of the previous frame, including a completed run in a frame that never ended.
- R12: Cycles with `rx_valid` low neither advance nor break a run.
- R13: A run whose last byte is the end-of-frame beat counts for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Wake-up frame detection enabled |
| accept_grp_bcast | input | 1 | Let multicast or broadcast matches qualify |
| station_addr | input | 48 | Station physical address, bits 7:0 sent first |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | Beat is the first of a frame |
| rx_eof | input | 1 | Beat is the last of a frame |
| rx_data | input | 8 | Received byte |
| hit_unicast | input | 1 | External filter: physical address match |
| hit_multicast | input | 1 | External filter: logical address match |
| hit_broadcast | input | 1 | External filter: broadcast match |
| detect | output | 1 | One-cycle pulse: wake-up frame found |

## Verification
The bench sweeps the run offset across twelve payload positions, with 15 or 16 copies, every combination of the three match inputs, and both settings of the accept bit. A design that counts the copies wrong, ignores the accept bit, or lets group matches through unconditionally then flips the result on some of these frames. Some frames end exactly on the last run byte, and some have idle beats inserted. An off-by-one at the end of the frame, or treating an idle beat as a break, would show up there. Directed frames cover the remaining cases: a run that starts inside the header (a design that scans the header would fire), a false start just before a real run (a naive restart would miss it), enable dropping after a run has completed, and a completed run left behind in an unterminated frame (a design that leaks state across start-of-frame would fire).

// File: rtl/mpd_pkg.sv
package mpd_pkg;

    localparam int ADDR_W     = 48;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;

    typedef struct packed {
        logic              sof;
        logic              eof;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;

    typedef struct packed {
        logic ucast;
        logic mcast;
        logic bcast;
    } addr_hit_t;

    function automatic logic hit_qualifies(input addr_hit_t h, input logic accept_grp);
        return h.ucast | (accept_grp & (h.mcast | h.bcast));
    endfunction

endpackage

// File: rtl/mpd_hdr_skip.sv
module mpd_hdr_skip #(
    parameter int HDR_LEN = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic beat_valid,
    input  logic beat_sof,
    output logic in_payload
);
    localparam int CW = $clog2(HDR_LEN + 1);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (beat_valid) begin
            if (beat_sof) begin
                seen_q <= CW'(1);
            end else if (seen_q < CW'(HDR_LEN)) begin
                seen_q <= seen_q + CW'(1);
            end
        end
    end

    assign in_payload = beat_valid & ~beat_sof & (seen_q == CW'(HDR_LEN));

endmodule

// File: rtl/mpd_run_scanner.sv
module mpd_run_scanner #(
    parameter int ADDR_BYTES = 6,
    parameter int REPEATS    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    advance,
    input  logic [7:0]              data,
    input  logic [8*ADDR_BYTES-1:0] addr,
    output logic                    run_done,
    output logic                    found
);
    localparam int BW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;

    logic [BW-1:0] byte_idx_q;
    logic [RW-1:0] rep_idx_q;
    logic [7:0]    want;
    logic          byte_hit;
    logic          last_byte;
    logic          last_rep;
    logic          first_hit;

    assign want      = addr[int'(byte_idx_q)*8 +: 8];
    assign byte_hit  = (data == want);
    assign first_hit = (data == addr[7:0]);
    assign last_byte = (byte_idx_q == BW'(ADDR_BYTES - 1));
    assign last_rep  = (rep_idx_q == RW'(REPEATS - 1));
    assign run_done  = advance & byte_hit & last_byte & last_rep;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            byte_idx_q <= '0;
            rep_idx_q  <= '0;
            found      <= 1'b0;
        end else if (advance) begin
            if (byte_hit) begin
                if (last_byte) begin
                    byte_idx_q <= '0;
                    rep_idx_q  <= last_rep ? '0 : rep_idx_q + RW'(1);
                    if (last_rep) begin
                        found <= 1'b1;
                    end
                end else begin
                    byte_idx_q <= byte_idx_q + BW'(1);
                end
            end else begin
                byte_idx_q <= first_hit ? BW'(1) : '0;
                rep_idx_q  <= '0;
            end
        end
    end

endmodule

// File: rtl/mpd_qualify.sv
module mpd_qualify
    import mpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      accept_grp,
    input  logic      eof_beat,
    input  logic      run_ok,
    input  addr_hit_t hits,
    output logic      detect
);
    always_ff @(posedge clk) begin
        if (rst) begin
            detect <= 1'b0;
        end else begin
            detect <= enable & eof_beat & run_ok & hit_qualifies(hits, accept_grp);
        end
    end

endmodule

// File: rtl/mp_frame_detector.sv
module mp_frame_detector
    import mpd_pkg::*;
#(
    parameter int HDR_LEN = 14,
    parameter int REPEATS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              accept_grp_bcast,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              hit_unicast,
    input  logic              hit_multicast,
    input  logic              hit_broadcast,
    output logic              detect
);
    rx_beat_t  beat;
    addr_hit_t hits;
    logic      in_payload;
    logic      scan_clear;
    logic      sc_done;
    logic      sc_found;

    assign beat       = '{sof: rx_sof, eof: rx_eof, data: rx_data};
    assign hits       = '{ucast: hit_unicast, mcast: hit_multicast, bcast: hit_broadcast};
    assign scan_clear = (rx_valid & beat.sof) | ~enable;

    mpd_hdr_skip #(.HDR_LEN(HDR_LEN)) hdr_i (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (rx_valid),
        .beat_sof   (beat.sof),
        .in_payload (in_payload)
    );

    mpd_run_scanner #(.ADDR_BYTES(ADDR_BYTES), .REPEATS(REPEATS)) scan_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (scan_clear),
        .advance  (in_payload & enable),
        .data     (beat.data),
        .addr     (station_addr),
        .run_done (sc_done),
        .found    (sc_found)
    );

    mpd_qualify qual_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .accept_grp (accept_grp_bcast),
        .eof_beat   (rx_valid & beat.eof),
        .run_ok     (sc_found | sc_done),
        .hits       (hits),
        .detect     (detect)
    );

endmodule

// File: rtl/mpd_checker.sv
module mpd_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic accept_grp_bcast,
    input logic rx_valid,
    input logic rx_eof,
    input logic hit_unicast,
    input logic hit_multicast,
    input logic hit_broadcast,
    input logic sc_found,
    input logic sc_done,
    input logic detect
);
    // R10: the pulse follows an end-of-frame beat
    p_after_eof_r10: assert property (@(posedge clk) disable iff (rst)
        detect |-> $past(rx_valid && rx_eof));

    // R10: never two cycles in a row
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        detect |=> !detect);

    // R9: gated by enable
    p_enable_gate_r9: assert property (@(posedge clk) disable iff (rst)
        detect |-> $past(enable));

    // R7: only qualifying matches let a frame through
    p_addr_qual_r7: assert property (@(posedge clk) disable iff (rst)
        detect |-> $past(hit_unicast || (accept_grp_bcast && (hit_multicast || hit_broadcast))));

    // R2: a completed run is behind every pulse
    p_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
        detect |-> $past(sc_found || sc_done));

endmodule

bind mp_frame_detector mpd_checker chk_i (
    .clk              (clk),
    .rst              (rst),
    .enable           (enable),
    .accept_grp_bcast (accept_grp_bcast),
    .rx_valid         (rx_valid),
    .rx_eof           (rx_eof),
    .hit_unicast      (hit_unicast),
    .hit_multicast    (hit_multicast),
    .hit_broadcast    (hit_broadcast),
    .sc_found         (sc_found),
    .sc_done          (sc_done),
    .detect           (detect)
);

// File: tb/mp_frame_detector_tb_top.sv
module mp_frame_detector_tb_top;

    localparam logic [47:0] ADDR = 48'h5E4D3C2B1A09;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        accept = 1'b0;
    logic [47:0] station_addr = ADDR;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        h_uc = 1'b0;
    logic        h_mc = 1'b0;
    logic        h_bc = 1'b0;
    logic        detect;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] frm [0:511];
    int         flen;
    logic       got_eof, got_next, seen_during;

    always #5 clk = ~clk;

    mp_frame_detector dut_i (
        .clk(clk), .rst(rst), .enable(enable), .accept_grp_bcast(accept),
        .station_addr(station_addr), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .hit_unicast(h_uc),
        .hit_multicast(h_mc), .hit_broadcast(h_bc), .detect(detect)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] abyte(input int i);
        return ADDR[i*8 +: 8];
    endfunction

    // header A0.., filler C0..CF, then `copies` address copies at beat `start`
    task automatic build(input int len, input int start, input int copies);
        flen = len;
        for (int i = 0; i < len; i++)
            frm[i] = (i < 14) ? 8'(8'hA0 + i) : 8'(8'hC0 + (i % 16));
        for (int k = 0; k < copies * 6; k++)
            frm[start + k] = abyte(k % 6);
    endtask

    // scan model written from R2, R4, R5
    function automatic logic model_found();
        int bi = 0, rep = 0;
        logic f = 1'b0;
        for (int i = 14; i < flen; i++) begin
            if (frm[i] == abyte(bi)) begin
                if (bi == 5 && rep == 15) begin f = 1'b1; bi = 0; rep = 0; end
                else if (bi == 5) begin bi = 0; rep++; end
                else bi++;
            end else begin
                bi  = (frm[i] == abyte(0)) ? 1 : 0;
                rep = 0;
            end
        end
        return f;
    endfunction

    task automatic send(input bit do_eof, input bit gaps, input int drop_at);
        seen_during = 1'b0;
        for (int i = 0; i < flen; i++) begin
            if (i == drop_at) begin
                for (int g = 0; g < 3; g++) begin
                    @(negedge clk);
                    if (detect) seen_during = 1'b1;
                    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; enable = 1'b0;
                end
                @(negedge clk);
                enable = 1'b1;
            end
            @(negedge clk);
            if (detect) seen_during = 1'b1;
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = do_eof && (i == flen - 1);
            rx_data  = frm[i];
            if (gaps && (i % 7 == 6) && i != flen - 1) begin
                @(negedge clk);
                if (detect) seen_during = 1'b1;
                rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'hFF;
            end
        end
        @(negedge clk);
        got_eof  = detect;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        got_next = detect;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp;
        repeat (3) @(negedge clk);
        check("R1 reset", detect, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", detect, 1'b0);

        // sweep: offset, copies, match inputs, accept bit (R2 R3 R6 R7 R8 R12 R13)
        for (int off = 0; off < 12; off++)
            for (int cp = 15; cp <= 16; cp++)
                for (int hc = 0; hc < 8; hc++)
                    for (int ac = 0; ac < 2; ac++) begin
                        build(14 + off + cp * 6 + (off % 3), 14 + off, cp);
                        h_uc = hc[0]; h_mc = hc[1]; h_bc = hc[2]; accept = ac[0];
                        exp = model_found() & (h_uc | (accept & (h_mc | h_bc)));
                        send(1'b1, off[0], -1);
                        check("R2/R3/R6/R7/R8/R12/R13 sweep", got_eof, exp);
                        if (exp) check("R10 single pulse", got_next | seen_during, 1'b0);
                    end

        h_uc = 1'b1; h_mc = 1'b0; h_bc = 1'b0; accept = 1'b0;

        // R4: run starting at beat 8 loses its first copy to the header
        build(130, 8, 16);
        send(1'b1, 1'b0, -1);
        check("R4 header not scanned", got_eof, 1'b0);
        build(130, 14, 16);
        send(1'b1, 1'b0, -1);
        check("R4 run at beat 14", got_eof, 1'b1);

        // R5: false start, breaking byte is first address byte
        build(140, 17, 16);
        frm[14] = abyte(0); frm[15] = abyte(1); frm[16] = abyte(2);
        send(1'b1, 1'b0, -1);
        check("R5 restart on first byte", got_eof, 1'b1);
        build(140, 16, 16);
        frm[14] = abyte(0); frm[15] = abyte(0);
        send(1'b1, 1'b0, -1);
        check("R5 restart repeated first byte", got_eof, 1'b1);
        // R3: one foreign byte inside the run
        build(140, 14, 16);
        frm[14 + 50] = 8'h77;
        send(1'b1, 1'b0, -1);
        check("R3 broken run", got_eof, 1'b0);
        // R3: run made of another address pattern
        build(140, 14, 0);
        for (int k = 14; k < 110; k++) frm[k] = 8'hFF;
        accept = 1'b1; h_bc = 1'b1; h_uc = 1'b0;
        send(1'b1, 1'b0, -1);
        check("R3 broadcast pattern not station", got_eof, 1'b0);
        h_uc = 1'b1; h_bc = 1'b0; accept = 1'b0;

        // R9: disabled for the whole frame
        build(130, 14, 16);
        enable = 1'b0;
        send(1'b1, 1'b0, -1);
        check("R9 disabled", got_eof, 1'b0);
        enable = 1'b1;
        // R9: enable dropped after the run completed
        build(130, 14, 16);
        send(1'b1, 1'b0, 115);
        check("R9 drop clears found", got_eof, 1'b0);
        check("R9 no pulse while dropped", seen_during, 1'b0);

        // R11: completed run in an unterminated frame, then a plain frame
        build(130, 14, 16);
        send(1'b0, 1'b0, -1);
        check("R11 no eof no pulse", got_eof, 1'b0);
        build(60, 14, 0);
        send(1'b1, 1'b0, -1);
        check("R11 sof clears state", got_eof, 1'b0);

        // R10: pulse timing on a clean frame
        build(120, 20, 16);
        send(1'b1, 1'b0, -1);
        check("R10 pulse after eof", got_eof, 1'b1);
        check("R10 pulse one cycle", got_next, 1'b0);
        check("R10 no early pulse", seen_during, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule